// File: doc/BRIEF.md
# Page ROM Page-Hit Detector

This block classifies each external ROM read cycle as a page hit or a page miss. It keeps the address of the most recent accepted cycle and compares it with the address of a new cycle, ignoring the low bits that select a word inside one page. When the two addresses fall in the same page, the memory controller may use the short page-access timing. Otherwise it has to use full random-access timing.

The page depth can be programmed. Four mask controls, one for each of address bits 3 through 6, take a bit out of the comparison when the control is set. This lets one comparator serve page ROMs with 4, 8, 16, 32 or 64 words per page on a 16-bit bus. Bits 0 to 2 are never compared and bits 7 to 23 are always compared. After reset, or after an invalidate pulse, the stored address is marked stale, so the next access is reported as a page miss.

Top module: `pgrom_hit_top`

## Requirements
- R1: After reset, `hit_o` and `miss_o` are both 0, and the stored address is treated as stale.
- R2: On a cycle with `strobe_i` high, the result appears in the next clock cycle: exactly one of `hit_o` and `miss_o` is 1. It stays there until the next strobe or invalidate.
- R3: Address bits 0 to 2 never take part in the comparison. Two addresses that differ only in those bits give a hit, provided the stored address is valid.
- R4: Address bits 7 to 23 always take part in the comparison. A difference in any of them gives a miss.
- R5: Bit k of `page_mask_i` (k = 0..3) controls address bit k+3. When the mask bit is 1, that address bit is ignored. When it is 0, a difference in that address bit gives a miss.
- R6: The mask is applied bit by bit, even when the set bits are not contiguous. No error is flagged.
- R7: The stored address is replaced on every strobe, hit or miss. Each comparison therefore uses the immediately preceding accepted address.
- R8: The first strobe after reset, or after an `inval_i` pulse, gives a miss, whatever the stored address holds.
- R9: An `inval_i` pulse clears both outputs in the next cycle. If `inval_i` and `strobe_i` are high together, the strobe is classified as a miss and its address is stored as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | Start of a page ROM read cycle |
| addr_i | input | 24 | Byte address of the current cycle |
| page_mask_i | input | 4 | Mask for address bits 3..6; a 1 excludes the bit |
| inval_i | input | 1 | Mark the stored address stale |
| hit_o | output | 1 | Registered page hit |
| miss_o | output | 1 | Registered page miss |

## Verification
A wrong stored address or a wrong valid flag shows up at the ports on the very next strobe. It appears one clock later as `hit_o` where `miss_o` was expected, or the reverse. The bench therefore checks every strobe against a model of the previous address and the valid state. It sweeps all 16 mask values against a flipped bit at every address position, so a comparator lane that is swapped or stuck is caught on the first classification that depends on that lane.

// File: rtl/pgrom_hit_pkg.sv
// Package: shared widths and the verdict type for the page-hit detector.
// Assumes a byte-addressed 24-bit external address.
package pgrom_hit_pkg;
    localparam int ADDR_W    = 24;
    localparam int FIX_LO_W  = 3;   // never compared
    localparam int MASK_W    = 4;   // programmable bits
    localparam int MASK_LSB  = FIX_LO_W;
    localparam int CMP_LSB   = FIX_LO_W + MASK_W;  // first always-compared bit

    typedef enum logic [1:0] {
        VERD_NONE = 2'b00,
        VERD_HIT  = 2'b01,
        VERD_MISS = 2'b10
    } verdict_t;
endpackage

// File: rtl/pgrom_addr_latch.sv
// Module: pgrom_addr_latch
// Holds the address of the last accepted cycle and a valid flag.
// Assumes: load and clear may arrive together; load wins for the valid flag.
module pgrom_addr_latch #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] prev_o,
    output logic          valid_o
);
    // Capture the address on every accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_o <= '0;
        else if (load_i) prev_o <= addr_i;
    end

    // Track whether the stored address may be trusted.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_o <= 1'b0;
        else if (load_i)  valid_o <= 1'b1;
        else if (clear_i) valid_o <= 1'b0;
    end

    // R8: a valid flag can only rise through a load
    p_valid_by_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(load_i));
endmodule

// File: rtl/pgrom_page_cmp.sv
// Module: pgrom_page_cmp
// Combinational comparator: one lane per compared bit, with masking.
// Assumes: bits below LO are ignored, and bits LO..LO+MW-1 follow mask_i.
module pgrom_page_cmp #(
    parameter int AW = 24,
    parameter int LO = 3,
    parameter int MW = 4
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] prev_i,
    input  logic [MW-1:0] mask_i,
    output logic          same_o
);
    localparam int HI_LSB = LO + MW;
    localparam int NLANE  = AW - LO;

    logic [NLANE-1:0] lane_eq;

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            if (g < MW) begin : g_prog
                // Programmable lane: masked lanes always agree.
                assign lane_eq[g] = mask_i[g] | (cur_i[LO+g] == prev_i[LO+g]);
            end else begin : g_fixed
                // Fixed lane: always compared.
                assign lane_eq[g] = (cur_i[LO+g] == prev_i[LO+g]);
            end
        end
    endgenerate

    // Reduce the per-lane results into one equality verdict.
    always_comb begin
        same_o = &lane_eq;
    end

    // R4: any difference in the fixed upper field must prevent a match
    always_comb begin
        if (same_o) begin
            a_upper_match_r4: assert (cur_i[AW-1:HI_LSB] == prev_i[AW-1:HI_LSB]);
        end
    end
endmodule

// File: rtl/pgrom_verdict_reg.sv
// Module: pgrom_verdict_reg
// Registers the hit/miss verdict; holds it until the next strobe or invalidate.
// Assumes: strobe and invalidate are single-cycle qualifiers.
module pgrom_verdict_reg
    import pgrom_hit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic inval_i,
    input  logic same_i,
    input  logic valid_i,
    output logic hit_o,
    output logic miss_o
);
    verdict_t verd_q, verd_d;

    // Choose the next verdict from the strobe, the comparison and the valid flag.
    always_comb begin
        verd_d = verd_q;
        if (strobe_i) begin
            if (valid_i && same_i && !inval_i) verd_d = VERD_HIT;
            else                               verd_d = VERD_MISS;
        end else if (inval_i) begin
            verd_d = VERD_NONE;
        end
    end

    // Hold the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) verd_q <= VERD_NONE;
        else        verd_q <= verd_d;
    end

    assign hit_o  = (verd_q == VERD_HIT);
    assign miss_o = (verd_q == VERD_MISS);

    // R2: the two flags never both assert
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));
    // R2: a strobe always yields exactly one flag a cycle later
    p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> $countones({hit_o, miss_o}) == 1);
    // R8: a stale address never produces a hit
    p_stale_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !valid_i) |=> miss_o);
    // R9: an invalidate with no strobe clears both flags
    p_inval_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_i && !strobe_i) |=> (!hit_o && !miss_o));
    // R2: with no strobe and no invalidate the flags hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !inval_i) |=> ($stable(hit_o) && $stable(miss_o)));
endmodule

// File: rtl/pgrom_hit_top.sv
// Module: pgrom_hit_top
// Page-hit detector for page ROM read cycles. The address of the previous
// accepted cycle is compared with the current one, with bits 0..2 ignored
// and bits 3..6 ignored per page_mask_i. The verdict is registered one clock
// after the strobe.
// Assumes: addr_i is stable while strobe_i is high.
module pgrom_hit_top
    import pgrom_hit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MASK_W-1:0] page_mask_i,
    input  logic              inval_i,
    output logic              hit_o,
    output logic              miss_o
);
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_valid;
    logic              same_page;

    pgrom_addr_latch #(.AW(ADDR_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (strobe_i),
        .clear_i (inval_i),
        .addr_i  (addr_i),
        .prev_o  (prev_addr),
        .valid_o (prev_valid)
    );

    pgrom_page_cmp #(.AW(ADDR_W), .LO(FIX_LO_W), .MW(MASK_W)) i_cmp (
        .cur_i  (addr_i),
        .prev_i (prev_addr),
        .mask_i (page_mask_i),
        .same_o (same_page)
    );

    pgrom_verdict_reg i_verd (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .inval_i  (inval_i),
        .same_i   (same_page),
        .valid_i  (prev_valid),
        .hit_o    (hit_o),
        .miss_o   (miss_o)
    );

    // R7: a strobe stores its own address
    p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (prev_addr == $past(addr_i)));
    // R1: out of reset nothing is flagged before the first strobe
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!hit_o && !miss_o));
endmodule

// File: tb/test_pgrom_hit_top.sv
// Bench: sweeps every mask value against a flipped bit at every address
// position, and checks validity, latch update and invalidate handling.
module test_pgrom_hit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [3:0]  page_mask_i = '0;
    logic        inval_i = 1'b0;
    logic        hit_o, miss_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    pgrom_hit_top i_pgrom_hit_top (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .addr_i(addr_i),
        .page_mask_i(page_mask_i), .inval_i(inval_i),
        .hit_o(hit_o), .miss_o(miss_o)
    );

    task automatic check(input string req, input logic eh, input logic em);
        n_chk++;
        if (hit_o !== eh || miss_o !== em) begin
            n_bad++;
            $display("FAIL %s: hit/miss got %b%b expected %b%b", req, hit_o, miss_o, eh, em);
        end
    endtask

    // Drive one strobe at the falling edge and sample the result after the next rising edge.
    task automatic access(input logic [23:0] a, input logic [3:0] m, input logic inv);
        @(negedge clk);
        addr_i = a; page_mask_i = m; strobe_i = 1'b1; inval_i = inv;
        @(negedge clk);
        strobe_i = 1'b0; inval_i = 1'b0;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval_i = 1'b1;
        @(negedge clk);
        inval_i = 1'b0;
    endtask

    // Expected verdict for addresses a and b with mask m, computed from the requirements.
    function automatic logic exp_same(input logic [23:0] a, input logic [23:0] b, input logic [3:0] m);
        logic [23:0] care;
        care = 24'hFFFF80 | {17'd0, ~m, 3'b000};
        return ((a ^ b) & care) == 24'd0;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [23:0] base;
        logic [23:0] other;
        logic        s;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);

        // R8: the first access after reset misses, even at the reset latch value (0)
        access(24'h000000, 4'h0, 1'b0);
        check("R8", 1'b0, 1'b1);
        // R2: the verdict holds while idle
        @(negedge clk);
        check("R2", 1'b0, 1'b1);
        access(24'h000004, 4'h0, 1'b0);
        check("R3", 1'b1, 1'b0);

        // Sweep over all masks and every flipped bit (R3, R4, R5, R6)
        base = 24'hA5_C3_5A;
        for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 24; b++) begin
                other = base ^ (24'd1 << b);
                access(base, m[3:0], 1'b0);
                access(other, m[3:0], 1'b0);
                s = exp_same(base, other, m[3:0]);
                if (b < 3)       check("R3", s, ~s);
                else if (b > 6)  check("R4", s, ~s);
                else if (m == 1 || m == 3 || m == 7 || m == 15 || m == 0)
                                 check("R5", s, ~s);
                else             check("R6", s, ~s);
            end
        end

        // R7: a miss still updates the latch
        access(24'h100000, 4'h0, 1'b0);
        access(24'h200000, 4'h0, 1'b0);
        check("R7", 1'b0, 1'b1);
        access(24'h200003, 4'h0, 1'b0);
        check("R7", 1'b1, 1'b0);

        // R9: invalidate clears the outputs, and the next access misses (R8)
        pulse_inval();
        check("R9", 1'b0, 1'b0);
        access(24'h200001, 4'h0, 1'b0);
        check("R8", 1'b0, 1'b1);
        access(24'h200002, 4'h0, 1'b0);
        check("R7", 1'b1, 1'b0);

        // R9: invalidate together with a strobe gives a miss but stores a valid address
        access(24'h200005, 4'h0, 1'b1);
        check("R9", 1'b0, 1'b1);
        access(24'h200006, 4'h0, 1'b0);
        check("R9", 1'b1, 1'b0);

        // R5: an 8-word page with mask 0001 on a bit-3 change
        access(24'h300000, 4'h1, 1'b0);
        access(24'h30000F, 4'h1, 1'b0);
        check("R5", 1'b1, 1'b0);
        access(24'h300010, 4'h1, 1'b0);
        check("R5", 1'b0, 1'b1);

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        access(24'h300010, 4'h0, 1'b0);
        check("R8", 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule